// File: doc/BRIEF.md
# Serial Receive Path with Line Status

This block takes an asynchronous serial line and turns it into characters. The line is sampled on a 16x oversampling enable. The frame format can be set for 5 to 8 data bits, with or without a parity bit (odd or even) and with one or two stop bits. Each finished character goes into a small receive queue together with three error tags of its own: parity, framing and break. The queue can be turned off, and it then acts as a single holding register.

A host reads through one strobe and one select line. One select value returns the character at the head of the queue and removes it. The other returns the line status byte. Data-ready, overrun, parity, framing and break are reported there. So are two transmitter bits taken from inputs, which are forced low while the transmitter sends a break. The error bits describe the head character only. A status read hides them until the head changes. In multidrop operation the parity position carries an address/data marker in place of a parity check.

The receiver is a state machine with six states. IDLE moves to START when the line is seen low on a tick. START returns to IDLE (false start) if the line is high at the eighth tick, and otherwise moves to DATA. DATA moves to PARITY after the last data bit when parity is on, and to STOP when it is off. PARITY always moves to STOP. STOP stays for a second stop sample when two stop bits are set. At the final stop sample STOP moves to BRKWAIT if every sample of the frame was low, and to IDLE in all other cases. BRKWAIT returns to IDLE once the line is seen high on a tick.

Top module: `uart_rx_top`

## Requirements
- R1: A low level seen in IDLE starts a character only if the line is still low 8 ticks later. Otherwise no character is stored and data-ready (status bit 0) stays 0.
- R2: Data bits arrive LSB first. Their count is 5 + cfg_len (cfg_len 0..3). They are followed by an optional parity bit and then 1 stop bit (cfg_stop2=0) or 2 stop bits (cfg_stop2=1). Unused upper data bits read as 0. Each bit is sampled 16 ticks after the previous sample.
- R3: With parity on and multidrop off, status bit 2 is 1 when the head character's parity bit does not give an even total (cfg_par_odd=0) or an odd total (cfg_par_odd=1) of ones over the data and parity bits.
- R4: Status bit 3 is 1 when any stop sample of the head character was 0.
- R5: A frame in which every sample is 0 stores exactly one character 0x00 with bit 3 = 1, bit 4 (break) = 1 and bit 2 = 0. No further character is stored until the line has returned high.
- R6: Bits 2, 3 and 4 belong to the head character. After the head is read out, they show the tags of the next character.
- R7: With the queue on (cfg_fifo_en=1), a character that completes while all DEPTH entries are full is dropped and status bit 1 (overrun) is set. When a status read falls in the same cycle as the overrun, the overrun still shows on the next read.
- R8: With the queue off, one character is held. A new character replaces an unread one and sets bit 1.
- R9: A status read (rd_sel=1) clears bits 1 to 4 and leaves bit 0 unchanged. A data read (rd_sel=0) returns the head character and removes it. When the queue is empty, a data read returns 0.
- R10: With parity on and cfg_mdrop=1, status bit 2 equals the received parity-position bit: 1 marks an address byte and 0 marks a data byte.
- R11: Status bit 5 = thr_empty_i and not tx_brk_i. Bit 6 = tx_idle_i and not tx_brk_i. Bit 7 = 0.
- R12: After reset the queue is empty and status bits 0 to 4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial receive line |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_fifo_en | input | 1 | Queue on when 1, single holding register when 0 |
| cfg_mdrop | input | 1 | Multidrop marker in place of parity check |
| thr_empty_i | input | 1 | Transmit holding empty from transmitter |
| tx_idle_i | input | 1 | Transmitter fully idle |
| tx_brk_i | input | 1 | Transmitter sending break |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | 1 | 0 = character, 1 = line status |
| rd_data | output | 8 | Read data for the current select |

## Verification
A status read and a character completion can fall in the same cycle. The first clears overrun and hides the head tags. The second may set overrun or change the head. The bench fills the queue and then sends one more character while it holds a status read in every cycle, so the completion is sure to land on a read. The test passes only if overrun is seen on exactly one read and data-ready never drops during the run. A later status read must show overrun cleared.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       pe;
        logic       fe;
        logic       bi;
    } rx_entry_t;

    localparam int ST_DR   = 0;
    localparam int ST_OE   = 1;
    localparam int ST_PE   = 2;
    localparam int ST_FE   = 3;
    localparam int ST_BI   = 4;
    localparam int ST_THRE = 5;
    localparam int ST_TEMT = 6;
endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic       cfg_mdrop,
    output logic       push,
    output rx_entry_t  entry
);
    rx_state_e st, st_nx;
    logic [3:0] cnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       par_bit, zero_q, fe_acc, stop_n;

    logic samp, mid_start, last_data, final_stop, brk_now;
    assign samp       = tick && (cnt == 4'd15);
    assign mid_start  = tick && (cnt == 4'd7);
    assign last_data  = (bidx == ({1'b0, cfg_len} + 3'd4));
    assign final_stop = samp && (!cfg_stop2 || stop_n);
    assign brk_now    = zero_q && !rxd;

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:    if (tick && !rxd) st_nx = RX_START;
            RX_START:   if (mid_start) st_nx = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:    if (samp && last_data) st_nx = cfg_par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:  if (samp) st_nx = RX_STOP;
            RX_STOP:    if (final_stop) st_nx = brk_now ? RX_BRKWAIT : RX_IDLE;
            RX_BRKWAIT: if (tick && rxd) st_nx = RX_IDLE;
            default:    st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; bidx <= '0; sh <= '0; par_bit <= 1'b0;
            zero_q <= 1'b1; fe_acc <= 1'b0; stop_n <= 1'b0;
            push <= 1'b0; entry <= '0;
        end else begin
            push <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0; bidx <= '0; sh <= '0; par_bit <= 1'b0;
                    zero_q <= 1'b1; fe_acc <= 1'b0; stop_n <= 1'b0;
                end
                RX_START: if (tick) cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                RX_DATA, RX_PARITY, RX_STOP: begin
                    if (tick) cnt <= cnt + 4'd1;
                    if (samp) begin
                        zero_q <= zero_q && !rxd;
                        if (st == RX_DATA) begin
                            sh[bidx] <= rxd;
                            bidx     <= bidx + 3'd1;
                        end
                        if (st == RX_PARITY) par_bit <= rxd;
                        if (st == RX_STOP) begin
                            fe_acc <= fe_acc || !rxd;
                            stop_n <= 1'b1;
                        end
                    end
                    if (st == RX_STOP && final_stop) begin
                        push       <= 1'b1;
                        entry.data <= brk_now ? 8'h00 : sh;
                        entry.fe   <= fe_acc || !rxd;
                        entry.bi   <= brk_now;
                        if (brk_now || !cfg_par_en) entry.pe <= 1'b0;
                        else if (cfg_mdrop)         entry.pe <= par_bit;
                        else                        entry.pe <= (^sh) ^ par_bit ^ cfg_par_odd;
                    end
                end
                RX_BRKWAIT: cnt <= '0;
                default: ;
            endcase
        end
    end

    // R1
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && mid_start && rxd) |=> (st == RX_IDLE && !push));

    // R2
    push_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st == RX_IDLE || st == RX_BRKWAIT));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      single,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    output rx_entry_t head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic      ovr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic full, do_pop, do_wr, do_ovw;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full   = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_pop = pop && (count != '0);
    assign do_wr  = push && (!full || do_pop);
    assign do_ovw = push && full && !do_pop && single;
    assign ovr    = push && full && !do_pop;
    assign head   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr)  mem[wp] <= wdata;
        if (do_ovw) mem[rp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp <= '0; wp <= '0; count <= '0;
        end else begin
            if (do_wr)  wp <= nxt(wp);
            if (do_pop) rp <= nxt(rp);
            count <= count + CW'(do_wr) - CW'(do_pop);
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic       cfg_fifo_en,
    input  logic       cfg_mdrop,
    input  logic       thr_empty_i,
    input  logic       tx_idle_i,
    input  logic       tx_brk_i,
    input  logic       rd_stb,
    input  logic       rd_sel,
    output logic [7:0] rd_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic      c_push, ovr, pop_ok, lsr_rd, head_change, head_clr, oe_q, dr, show;
    rx_entry_t c_entry, head;
    logic [CW-1:0] count;
    logic [7:0] lsr;

    uart_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_mdrop(cfg_mdrop),
        .push(c_push), .entry(c_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .single(!cfg_fifo_en),
        .push(c_push), .wdata(c_entry), .pop(rd_stb && !rd_sel),
        .head(head), .count(count), .ovr(ovr)
    );

    assign dr          = (count != '0);
    assign pop_ok      = rd_stb && !rd_sel && dr;
    assign lsr_rd      = rd_stb && rd_sel;
    assign head_change = pop_ok || (c_push && (!dr || !cfg_fifo_en));
    assign show        = dr && !head_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_clr <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            if (head_change) head_clr <= 1'b0;
            else if (lsr_rd) head_clr <= 1'b1;
            if (ovr)         oe_q <= 1'b1;
            else if (lsr_rd) oe_q <= 1'b0;
        end
    end

    always_comb begin
        lsr          = '0;
        lsr[ST_DR]   = dr;
        lsr[ST_OE]   = oe_q;
        lsr[ST_PE]   = show && head.pe;
        lsr[ST_FE]   = show && head.fe;
        lsr[ST_BI]   = show && head.bi;
        lsr[ST_THRE] = thr_empty_i && !tx_brk_i;
        lsr[ST_TEMT] = tx_idle_i && !tx_brk_i;
        rd_data      = rd_sel ? lsr : (dr ? head.data : 8'h00);
    end

    // R7
    fifo_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_push && cfg_fifo_en && count == CW'(DEPTH) && !pop_ok) |=> (oe_q && count == CW'(DEPTH)));

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !c_push) |=> (lsr[4:1] == 4'b0000));

    // R5
    break_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_push && c_entry.bi) |-> (c_entry.fe && c_entry.data == 8'h00 && !c_entry.pe));

    // R9
    dr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && dr) |=> dr);
endmodule

// File: tb/sim_uart_rx_top.sv
module sim_uart_rx_top;
    logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_fifo_en = 1, cfg_mdrop = 0;
    logic thr_empty_i = 1, tx_idle_i = 1, tx_brk_i = 0;
    logic rd_stb = 0, rd_sel = 0;
    logic [7:0] rd_data;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    uart_rx_top #(.DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .cfg_fifo_en(cfg_fifo_en), .cfg_mdrop(cfg_mdrop), .thr_empty_i(thr_empty_i),
        .tx_idle_i(tx_idle_i), .tx_brk_i(tx_brk_i), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    function automatic logic [7:0] len_mask(input int len);
        return 8'((1 << len) - 1);
    endfunction
    function automatic logic par_of(input logic [7:0] d, input int len, input logic odd);
        return (^(d & len_mask(len))) ^ odd;
    endfunction
    function automatic logic [7:0] st_base();
        return {1'b0, tx_idle_i & ~tx_brk_i, thr_empty_i & ~tx_brk_i, 5'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk); rd_sel = sel; rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic bit_time(input logic v);
        rxd = v; repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int len, input logic pbit, input logic bad_stop);
        bit_time(1'b0);
        for (int i = 0; i < len; i++) bit_time(d[i]);
        if (cfg_par_en) bit_time(pbit);
        if (bad_stop) begin
            rxd = 1'b0; repeat (24) @(negedge clk);
            rxd = 1'b1; repeat (8) @(negedge clk);
        end else bit_time(1'b1);
        if (cfg_stop2) bit_time(1'b1);
        rxd = 1'b1; repeat (40) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d, e;
        int len, seen_oe, dr_low;
        logic bad_par, bad_stop, pb;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 reset state
        rd(1'b1, v); chk("R12 status after reset", v, st_base());
        rd(1'b0, v); chk("R9 empty data read", v, 8'h00);

        // R2 R3 R4 R9 random frames
        for (int k = 0; k < 30; k++) begin
            cfg_len = 2'($urandom_range(0, 3)); len = 5 + int'(cfg_len);
            cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom); cfg_stop2 = 1'($urandom);
            d = 8'($urandom); bad_stop = 1'($urandom_range(0, 3) == 0);
            if (bad_stop) d[0] = 1'b1;
            bad_par = cfg_par_en & 1'($urandom);
            pb = par_of(d, len, cfg_par_odd) ^ bad_par;
            send(d, len, pb, bad_stop);
            e = st_base() | 8'h01 | {4'b0, bad_stop, bad_par, 2'b0};
            rd(1'b1, v); chk("R3 R4 random status", v, e);
            rd(1'b1, v); chk("R9 status after clear", v, st_base() | 8'h01);
            rd(1'b0, v); chk("R2 random data", v, d & len_mask(len));
            rd(1'b1, v); chk("R9 empty after pop", v, st_base());
        end

        cfg_len = 2'd3; cfg_par_en = 0; cfg_stop2 = 0; cfg_fifo_en = 1;

        // R1 false start
        rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1; repeat (600) @(negedge clk);
        rd(1'b1, v); chk("R1 false start stores nothing", v, st_base());

        // R6 per-head tags
        send(8'hA5, 8, 1'b0, 1'b0);
        send(8'h3C, 8, 1'b0, 1'b1);
        rd(1'b1, v); chk("R6 head good", v, st_base() | 8'h01);
        rd(1'b0, v); chk("R6 first data", v, 8'hA5);
        rd(1'b1, v); chk("R6 next head framing", v, st_base() | 8'h09);
        rd(1'b0, v); chk("R6 second data", v, 8'h3C);

        // R7 overrun coinciding with continuous status reads
        for (int i = 0; i < 4; i++) send(8'(8'h10 + i), 8, 1'b0, 1'b0);
        seen_oe = 0; dr_low = 0;
        fork
            send(8'h77, 8, 1'b0, 1'b0);
            begin
                @(negedge clk); rd_sel = 1'b1; rd_stb = 1'b1;
                for (int c = 0; c < 400; c++) begin
                    #1; if (rd_data[1]) seen_oe++; if (!rd_data[0]) dr_low++;
                    @(negedge clk);
                end
                rd_stb = 1'b0;
            end
        join
        chk("R7 overrun seen exactly once", 8'(seen_oe), 8'd1);
        chk("R9 data ready held", 8'(dr_low), 8'd0);
        rd(1'b1, v); chk("R7 overrun cleared", v, st_base() | 8'h01);
        for (int i = 0; i < 4; i++) begin
            rd(1'b0, v); chk("R7 kept entries", v, 8'(8'h10 + i));
        end
        rd(1'b1, v); chk("R7 dropped char absent", v, st_base());

        // R8 holding register mode
        cfg_fifo_en = 0;
        send(8'h11, 8, 1'b0, 1'b0);
        send(8'h22, 8, 1'b0, 1'b0);
        rd(1'b1, v); chk("R8 overrun no queue", v, st_base() | 8'h03);
        rd(1'b0, v); chk("R8 newest kept", v, 8'h22);
        rd(1'b1, v); chk("R8 single entry", v, st_base());
        cfg_fifo_en = 1;

        // R5 break
        rxd = 1'b0; repeat (800) @(negedge clk); rxd = 1'b1; repeat (100) @(negedge clk);
        rd(1'b1, v); chk("R5 break status", v, st_base() | 8'h19);
        rd(1'b0, v); chk("R5 break null", v, 8'h00);
        rd(1'b1, v); chk("R5 one entry only", v, st_base());

        // R10 multidrop
        cfg_par_en = 1; cfg_mdrop = 1; cfg_par_odd = 0;
        send(8'h42, 8, 1'b1, 1'b0);
        rd(1'b1, v); chk("R10 address marker", v, st_base() | 8'h05);
        rd(1'b0, v); chk("R10 address data", v, 8'h42);
        send(8'h43, 8, 1'b0, 1'b0);
        rd(1'b1, v); chk("R10 data marker", v, st_base() | 8'h01);
        rd(1'b0, v);
        cfg_mdrop = 0; cfg_par_en = 0;

        // R11 transmitter bits
        tx_brk_i = 1;
        rd(1'b1, v); chk("R11 break hides thre", v, 8'h00);
        tx_brk_i = 0; thr_empty_i = 0;
        rd(1'b1, v); chk("R11 thre follows input", v, 8'h40);
        thr_empty_i = 1;
        rd(1'b1, v); chk("R11 both set", v, 8'h60);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule